// File: doc/BRIEF.md
# Iterative 64-bit Feistel Block Cipher Engine

This engine encrypts or deciphers one 64-bit block under a 128-bit key with the XTEA-style Feistel network. A single round datapath does the work in both directions: a shift-and-XOR mixer, a modular adder or subtractor, and a key-word selector. That datapath updates one 32-bit half per clock. The direction bit swaps the roles of the two halves, swaps the two key-index rules, and makes the running sum count down instead of up. No round counter is kept. The loop stops when the running sum equals the end value for the chosen direction.

A user drives the block, the key and the direction bit, then pulses `start` while `busy` is low. The engine copies those inputs on that edge and runs 64 half-rounds. It then loads the result into `dout` and raises `done` for one cycle. `dout` keeps that value until the next operation finishes. A `start` that arrives while the engine is working has no effect.

Top module: `feistel64_core`

## Requirements
- R1: While and right after the synchronous reset, `busy` and `done` are 0 and `dout` is all zeros.
- R2: With `decrypt`=0 the result is the XTEA encryption of the block, with these conventions. The first half v0 is `din[63:32]` and the second half v1 is `din[31:0]`. Key word K0 is `key[127:96]`, K1 is `key[95:64]`, K2 is `key[63:32]` and K3 is `key[31:0]`. The per-cycle update on v0 uses K[sum & 3], and the one on v1 uses K[(sum >> 11) & 3] after sum has grown by 0x9E3779B9. The result is `dout` = {v0, v1}.
- R3: With `decrypt`=1 the result is the matching inverse. sum starts at 0xC6EF3720 and falls by 0x9E3779B9 per cycle. v1 is reduced first, using the pre-decrement sum, and v0 after it. All arithmetic is modulo 2^32 with logical shifts.
- R4: Deciphering an encrypted block under the same key returns the original block.
- R5: `done` rises exactly 64 clock edges after the edge that accepts `start`, and `busy` is high from that accept until `done`.
- R6: `done` lasts one cycle, and `busy` is low while `done` is high.
- R7: A `start` pulse while `busy` is high leaves the running operation, its result and its latency unchanged.
- R8: `dout` changes only in a cycle where `done` is high, and otherwise holds its last result.
- R9: Changing `din`, `key` or `decrypt` after the accept edge has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, taken only while idle |
| decrypt | input | 1 | 0 selects encryption, 1 selects decryption |
| key | input | 128 | Four 32-bit key words, K0 in the top bits |
| din | input | 64 | Input block, v0 in the top half |
| dout | output | 64 | Result block, registered and held |
| busy | output | 1 | High while an operation runs |
| done | output | 1 | One-cycle completion flag |

## Verification
The engine is run on fixed-seed random keys and blocks in both directions. Each result is compared with a reference model in the bench. A mistake in the half-swap, the key-index rule or the sum direction shows up in almost every random vector. Every random block is also encrypted and then deciphered, and must come back unchanged. That round trip exposes an asymmetry between the two directions that a one-direction check would miss. Directed cases use the all-zero and all-ones key and data, where a wrong shift width or carry chain stands out. Other directed cases change the inputs and pulse `start` in the middle of a run, to show that the captured operands and the latency are not disturbed.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fc_state_e;

  // Shift-XOR mixer applied to the source half before keying.
  function automatic logic [31:0] fc_mix32(input logic [31:0] x,
                                           input int unsigned shl,
                                           input int unsigned shr);
    return ((x << shl) ^ (x >> shr)) + x;
  endfunction

endpackage

// File: rtl/fc_keymux.sv
module fc_keymux #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  localparam int IDX_W = $clog2(NWORDS)
) (
  input  logic [NWORDS*WORD_W-1:0] key_flat,
  input  logic [IDX_W-1:0]         idx,
  output logic [WORD_W-1:0]        word
);

  logic [WORD_W-1:0] words [NWORDS];

  // Word 0 occupies the most significant slice.
  for (genvar g = 0; g < NWORDS; g++) begin : g_split
    assign words[g] = key_flat[(NWORDS-g)*WORD_W-1 -: WORD_W];
  end

  assign word = words[idx];

endmodule

// File: rtl/fc_halfround.sv
module fc_halfround #(
  parameter int WORD_W = 32,
  parameter int SHL    = 4,
  parameter int SHR    = 5,
  parameter int KSHIFT = 11,
  localparam int KEY_W = 4*WORD_W
) (
  input  logic [WORD_W-1:0] v0,
  input  logic [WORD_W-1:0] v1,
  input  logic [WORD_W-1:0] sum,
  input  logic [KEY_W-1:0]  key_q,
  input  logic              phase,
  input  logic              dec,
  output logic              dst_is_v1,
  output logic [WORD_W-1:0] new_word
);

  logic [WORD_W-1:0] src, dst, mixed, kword, keyed, f;
  logic [1:0]        idx;

  // Encrypt: phase0 writes v0 with low index, phase1 writes v1 with high index.
  // Decrypt mirrors both choices, so one XOR picks them.
  assign dst_is_v1 = phase ^ dec;
  assign src       = dst_is_v1 ? v0 : v1;
  assign dst       = dst_is_v1 ? v1 : v0;
  assign idx       = dst_is_v1 ? sum[KSHIFT+1:KSHIFT] : sum[1:0];

  fc_keymux #(.WORD_W(WORD_W), .NWORDS(4)) u_keymux (
    .key_flat (key_q),
    .idx      (idx),
    .word     (kword)
  );

  always_comb begin
    mixed    = ((src << SHL) ^ (src >> SHR)) + src;
    keyed    = sum + kword;
    f        = mixed ^ keyed;
    new_word = dec ? (dst - f) : (dst + f);
  end

endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl #(
  parameter int ROUNDS = 32,
  localparam int HALF_STEPS = 2*ROUNDS,
  localparam int CNT_W = $clog2(HALF_STEPS+1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic sum_at_limit,
  output logic load,
  output logic step,
  output logic phase,
  output logic finish,
  output logic busy,
  output logic done
);
  import fc_pkg::*;

  fc_state_e state;
  logic      done_q;

  assign busy   = (state == ST_RUN);
  assign load   = (state == ST_IDLE) && start;
  assign step   = busy;
  assign finish = busy && phase && sum_at_limit;
  assign done   = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      phase  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (load) begin
        state <= ST_RUN;
        phase <= 1'b0;
      end else if (busy) begin
        phase <= ~phase;
        if (finish) state <= ST_IDLE;
      end
    end
  end

  // Checker state: run-length counter and an armed flag.
  logic [CNT_W-1:0] run_cnt;
  logic             armed;
  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      armed   <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (load)               run_cnt <= '0;
      else if (busy && run_cnt != CNT_W'(HALF_STEPS)) run_cnt <= run_cnt + 1'b1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (armed && done) |-> (!busy && $past(busy))); // R6
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_cnt == CNT_W'(HALF_STEPS))); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(busy) && $past(start) && busy) |-> (phase != $past(phase))); // R7

endmodule

// File: rtl/feistel64_core.sv
module feistel64_core #(
  parameter int          WORD_W = 32,
  parameter int          ROUNDS = 32,
  parameter logic [31:0] DELTA  = 32'h9E37_79B9,
  parameter int          SHL    = 4,
  parameter int          SHR    = 5,
  parameter int          KSHIFT = 11,
  localparam int BLK_W = 2*WORD_W,
  localparam int KEY_W = 4*WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             decrypt,
  input  logic [KEY_W-1:0] key,
  input  logic [BLK_W-1:0] din,
  output logic [BLK_W-1:0] dout,
  output logic             busy,
  output logic             done
);

  localparam int                WIDE_W = 2*WORD_W;
  localparam logic [WIDE_W-1:0] TOTAL  = WIDE_W'(DELTA) * WIDE_W'(ROUNDS);
  localparam logic [WORD_W-1:0] LIMIT  = TOTAL[WORD_W-1:0];
  localparam logic [WORD_W-1:0] STEP   = DELTA[WORD_W-1:0];

  logic [WORD_W-1:0] v0, v1, sum, new_word;
  logic [KEY_W-1:0]  key_q;
  logic              dec_q, dst_is_v1;
  logic              load, step, phase, finish, sum_at_limit;

  assign sum_at_limit = (sum == (dec_q ? '0 : LIMIT));

  fc_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .sum_at_limit (sum_at_limit),
    .load         (load),
    .step         (step),
    .phase        (phase),
    .finish       (finish),
    .busy         (busy),
    .done         (done)
  );

  fc_halfround #(
    .WORD_W (WORD_W),
    .SHL    (SHL),
    .SHR    (SHR),
    .KSHIFT (KSHIFT)
  ) u_half (
    .v0        (v0),
    .v1        (v1),
    .sum       (sum),
    .key_q     (key_q),
    .phase     (phase),
    .dec       (dec_q),
    .dst_is_v1 (dst_is_v1),
    .new_word  (new_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v0    <= '0;
      v1    <= '0;
      sum   <= '0;
      key_q <= '0;
      dec_q <= 1'b0;
      dout  <= '0;
    end else begin
      if (load) begin
        v0    <= din[BLK_W-1:WORD_W];
        v1    <= din[WORD_W-1:0];
        key_q <= key;
        dec_q <= decrypt;
        sum   <= decrypt ? LIMIT : '0;
      end else if (step) begin
        if (dst_is_v1) v1 <= new_word;
        else           v0 <= new_word;
        if (!phase) sum <= dec_q ? (sum - STEP) : (sum + STEP);
        if (finish) dout <= dst_is_v1 ? {v0, new_word} : {new_word, v1};
      end
    end
  end

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (armed && !done) |-> $stable(dout)); // R8
  AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(busy) && busy) |-> ($stable(key_q) && $stable(dec_q))); // R9
  AST_SUM_START: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(load)) |-> (sum == ($past(decrypt) ? LIMIT : '0))); // R3

endmodule

// File: tb/feistel64_core_tb.sv
module feistel64_core_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         decrypt = 1'b0;
  logic [127:0] key = '0;
  logic [63:0]  din = '0;
  logic [63:0]  dout;
  logic         busy, done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  feistel64_core u_dut (
    .clk(clk), .rst(rst), .start(start), .decrypt(decrypt),
    .key(key), .din(din), .dout(dout), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic [31:0] kw(input [127:0] k, input [1:0] i);
    return k[127-32*i -: 32];
  endfunction

  function automatic [31:0] mx(input [31:0] x);
    return ((x << 4) ^ (x >> 5)) + x;
  endfunction

  function automatic [63:0] ref_enc(input [127:0] k, input [63:0] d);
    logic [31:0] a, b, s;
    a = d[63:32]; b = d[31:0]; s = 32'd0;
    for (int i = 0; i < 32; i++) begin
      a = a + (mx(b) ^ (s + kw(k, s[1:0])));
      s = s + 32'h9E3779B9;
      b = b + (mx(a) ^ (s + kw(k, s[12:11])));
    end
    return {a, b};
  endfunction

  function automatic [63:0] ref_dec(input [127:0] k, input [63:0] d);
    logic [31:0] a, b, s;
    a = d[63:32]; b = d[31:0]; s = 32'hC6EF3720;
    for (int i = 0; i < 32; i++) begin
      b = b - (mx(a) ^ (s + kw(k, s[12:11])));
      s = s - 32'h9E3779B9;
      a = a - (mx(b) ^ (s + kw(k, s[1:0])));
    end
    return {a, b};
  endfunction

  task automatic chk(input bit ok, input string req, input [63:0] act, input [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Runs one operation; optionally disturbs inputs and pulses start mid-run.
  task automatic run_op(input bit dec, input [127:0] k, input [63:0] d,
                        input bit disturb, output [63:0] res, output int lat);
    @(negedge clk);
    decrypt = dec; key = k; din = d; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done) break;
      if (lat > 200) break;
      if (disturb && lat == 10) begin
        start = 1'b1; din = ~d; key = ~k; decrypt = ~dec;
      end
      if (disturb && lat == 11) start = 1'b0;
      if (!busy) begin
        chk(1'b0, "R5 busy dropped early", {63'd0, busy}, 64'd1);
        break;
      end
    end
    res = dout;
    chk(!busy, "R6 busy low with done", {63'd0, busy}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk(!done, "R6 done one cycle", {63'd0, done}, 64'd0);
  endtask

  initial begin
    logic [63:0]  r, r2, e, held;
    logic [127:0] k;
    logic [63:0]  d;
    int           lat;

    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && dout == 64'd0, "R1 state in reset", dout, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && dout == 64'd0, "R1 state after reset", {62'd0, busy, done}, 64'd0);

    // Directed corner cases
    run_op(1'b0, '0, '0, 1'b0, r, lat);
    chk(r == ref_enc('0, '0), "R2 zero key zero block", r, ref_enc('0, '0));
    chk(lat == 64, "R5 latency", 64'(lat), 64'd64);
    run_op(1'b0, '1, '1, 1'b0, r, lat);
    chk(r == ref_enc('1, '1), "R2 ones key ones block", r, ref_enc('1, '1));
    run_op(1'b1, '1, '1, 1'b0, r, lat);
    chk(r == ref_dec('1, '1), "R3 ones key ones block", r, ref_dec('1, '1));
    chk(lat == 64, "R5 latency decrypt", 64'(lat), 64'd64);

    // Random in both directions plus round trip
    for (int n = 0; n < 30; n++) begin
      k = {$urandom, $urandom, $urandom, $urandom};
      d = {$urandom, $urandom};
      run_op(1'b0, k, d, 1'b0, r, lat);
      e = ref_enc(k, d);
      chk(r == e, "R2 random encrypt", r, e);
      chk(lat == 64, "R5 latency random", 64'(lat), 64'd64);
      run_op(1'b1, k, r, 1'b0, r2, lat);
      chk(r2 == d, "R4 round trip", r2, d);
      run_op(1'b1, k, d, 1'b0, r2, lat);
      e = ref_dec(k, d);
      chk(r2 == e, "R3 random decrypt", r2, e);
    end

    // R7 / R9: disturbed inputs and start pulse while busy
    for (int n = 0; n < 4; n++) begin
      k = {$urandom, $urandom, $urandom, $urandom};
      d = {$urandom, $urandom};
      run_op(n[0], k, d, 1'b1, r, lat);
      e = n[0] ? ref_dec(k, d) : ref_enc(k, d);
      chk(r == e, "R7 R9 result under mid-run start and input change", r, e);
      chk(lat == 64, "R7 latency under mid-run start", 64'(lat), 64'd64);
    end

    // R8: dout holds while idle with changing inputs
    held = dout;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      din = {$urandom, $urandom}; key = {$urandom, $urandom, $urandom, $urandom};
      decrypt = ~decrypt;
    end
    @(negedge clk);
    chk(dout == held && !busy, "R8 dout held while idle", dout, held);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule